// File: doc/BRIEF.md
# High/Low-Time Programmable Clock Divider

This block divides an input clock by an integer ratio taken from one packed setting word. The word gives a high-phase count and a low-phase count in input cycles, an odd-ratio adjust flag that moves half an input cycle from the low phase to the high phase so odd ratios stay near 50% duty, and a pass-through flag that sends the input clock straight to the output. A new word is captured on a load strobe. It is applied only at the end of a complete output period, so the output never carries a runt pulse.

A combinational helper turns an integer divide ratio into the matching setting word. Software or a neighbouring block can use it to build words. The setting word and the ratio are plain control values with no handshake. A load replaces any earlier word that has not yet been applied.

Top module: `hlclk_divider`

## Requirements
- R1: The encoder output for a ratio N in 2..126 has low count ceil(N/2) in bits [5:0], high count floor(N/2) in bits [11:6], the odd-adjust flag in bit 12 set exactly when N is odd, and the pass-through flag in bit 13 clear.
- R2: The encoder treats a ratio of 0 as 1 and a ratio above 126 as 126. For a ratio of 1 it sets the pass-through flag (bit 13), with high count 0, low count 1 and odd-adjust 1.
- R3: With pass-through clear, the output period is high count plus low count input cycles, where a count of zero counts as one.
- R4: With odd-adjust clear, each output period starts at an input rising edge with the high phase, which lasts exactly the high count in input cycles; the low phase lasts the low count.
- R5: With odd-adjust set and a low count of at least 2, the high phase lasts the high count plus half an input cycle and the low phase lasts the low count minus half a cycle.
- R6: The odd-adjust flag has no effect when the low count is below 2.
- R7: With pass-through set, the output equals the input clock.
- R8: A loaded word takes effect at the first period end after the load edge. In pass-through mode every input cycle is a period end. When switching between two divided settings, and when leaving pass-through, every output pulse has the width of either the old or the new setting.
- R9: While reset is asserted the output is low. After release the active setting is divide-by-2 (high 1, low 1), and the output rises at the first input rising edge after release.
- R10: If several words are loaded before a period end, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 14 | Setting word: low count, high count, odd-adjust, pass-through |
| cfg_load | input | 1 | Captures cfg_word at the input rising edge |
| enc_ratio | input | 7 | Integer divide ratio for the encoder |
| enc_word | output | 14 | Setting word encoding enc_ratio |
| clk_out | output | 1 | Divided clock |

## Verification
The output is sampled in both halves of every input cycle, and the widths of its high and low runs are measured in half cycles. Even ratios, asymmetric counts, zero counts, odd ratios up to the largest, and odd-adjust with a one-cycle low phase each give a distinct run pattern. This separates a wrong sum, a missing or misplaced half-cycle stretch, and a wrongly applied stretch. Switches between divided settings, leaving pass-through, and two loads inside one long period are recorded across the change. Any run that belongs to neither the old nor the last loaded setting exposes an early switch or a runt. Encoder words are compared bit by bit at small, odd, even, zero and saturating ratios, and one encoded word is applied to the divider.

// File: rtl/hlclk_pkg.sv
`timescale 1ns/1ps
package hlclk_pkg;
  localparam int CNT_W     = 6;
  localparam int RATIO_W   = CNT_W + 1;
  localparam int MAX_CNT   = (1 << CNT_W) - 1;
  localparam int MAX_RATIO = 2 * MAX_CNT;
  localparam int WORD_W    = 2 * CNT_W + 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic bypass;
    logic odd_adj;
    cnt_t high_cnt;
    cnt_t low_cnt;
  } div_cfg_t;

  localparam div_cfg_t RESET_CFG = '{bypass: 1'b0, odd_adj: 1'b0,
                                     high_cnt: cnt_t'(1), low_cnt: cnt_t'(1)};

  // a zero count behaves as a one-cycle phase
  function automatic cnt_t eff_cnt(input cnt_t c);
    return (c == '0) ? cnt_t'(1) : c;
  endfunction

  function automatic div_cfg_t encode_ratio(input logic [RATIO_W-1:0] ratio);
    logic [RATIO_W-1:0] n;
    div_cfg_t w;
    if (ratio == '0)
      n = RATIO_W'(1);
    else if (ratio > RATIO_W'(MAX_RATIO))
      n = RATIO_W'(MAX_RATIO);
    else
      n = ratio;
    w.high_cnt = n[RATIO_W-1:1];
    w.low_cnt  = n[RATIO_W-1:1] + cnt_t'(n[0]);
    w.odd_adj  = n[0];
    w.bypass   = (n == RATIO_W'(1));
    return w;
  endfunction
endpackage

// File: rtl/hlclk_encoder.sv
`timescale 1ns/1ps
module hlclk_encoder
  import hlclk_pkg::*;
(
  input  logic [RATIO_W-1:0] ratio,
  output div_cfg_t           word
);
  always_comb begin
    word = encode_ratio(ratio);
    AST_ENC_SPLIT: assert ({1'b0, word.low_cnt} == {1'b0, word.high_cnt} + {{CNT_W{1'b0}}, word.odd_adj}); // R1
    AST_ENC_BYP: assert (word.bypass == (word.high_cnt == '0)); // R2
  end
endmodule

// File: rtl/hlclk_cfg_hold.sv
`timescale 1ns/1ps
module hlclk_cfg_hold
  import hlclk_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  logic     load,
  input  div_cfg_t word_in,
  input  logic     period_end,
  output div_cfg_t act_cfg,
  output div_cfg_t nxt_cfg,
  output logic     stretch_en
);
  div_cfg_t pend_q;
  div_cfg_t act_q;
  logic     pend_vld_q;

  // the pending word replaces the active one only on a period boundary
  always_comb nxt_cfg = (period_end && pend_vld_q) ? pend_q : act_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= RESET_CFG;
      pend_q     <= RESET_CFG;
      pend_vld_q <= 1'b0;
    end else begin
      act_q <= nxt_cfg;
      if (load) begin
        pend_q     <= word_in;
        pend_vld_q <= 1'b1;
      end else if (period_end) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign act_cfg    = act_q;
  assign stretch_en = act_q.odd_adj && !act_q.bypass && (act_q.low_cnt >= cnt_t'(2));

  AST_CFG_AT_END: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(period_end)); // R8
endmodule

// File: rtl/hlclk_phase_ctr.sv
`timescale 1ns/1ps
module hlclk_phase_ctr
  import hlclk_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  div_cfg_t act_cfg,
  input  div_cfg_t nxt_cfg,
  output logic     phase_hi,
  output logic     period_end
);
  cnt_t cnt_q;
  cnt_t hi_e;
  cnt_t lo_e;
  logic ph_q;
  logic boot_q;

  always_comb begin
    hi_e = eff_cnt(act_cfg.high_cnt);
    lo_e = eff_cnt(act_cfg.low_cnt);
  end

  assign period_end = boot_q | act_cfg.bypass | (!ph_q && (cnt_q == lo_e - cnt_t'(1)));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (period_end) begin
        ph_q  <= !nxt_cfg.bypass;
        cnt_q <= '0;
      end else if (ph_q && (cnt_q == hi_e - cnt_t'(1))) begin
        ph_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end

  assign phase_hi = ph_q;

  AST_HI_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
    ph_q |-> (cnt_q < hi_e)); // R4
  AST_LO_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!ph_q && !act_cfg.bypass) |-> (cnt_q < lo_e)); // R3
  AST_RISE_AT_END: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(ph_q) |-> $past(period_end)); // R8
  AST_BYP_PHASE_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    act_cfg.bypass |-> !ph_q); // R7
endmodule

// File: rtl/hlclk_out_gate.sv
`timescale 1ns/1ps
module hlclk_out_gate (
  input  logic clk_in,
  input  logic rst_n,
  input  logic phase_hi,
  input  logic stretch_en,
  input  logic byp_sel,
  output logic clk_out
);
  logic tail_q;
  logic byp_en_q;

  // falling-edge copies: the tail extends high by half a cycle, and the
  // pass-through enable only moves while the input clock is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      tail_q   <= 1'b0;
      byp_en_q <= 1'b0;
    end else begin
      tail_q   <= phase_hi;
      byp_en_q <= byp_sel;
    end
  end

  assign clk_out = phase_hi | (stretch_en & tail_q) | (byp_en_q & clk_in);

  AST_RESET_QUIET: assert property (@(posedge clk_in)
    !rst_n |-> !clk_out); // R9
endmodule

// File: rtl/hlclk_divider.sv
`timescale 1ns/1ps
module hlclk_divider
  import hlclk_pkg::*;
(
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  cfg_word,
  input  logic               cfg_load,
  input  logic [RATIO_W-1:0] enc_ratio,
  output logic [WORD_W-1:0]  enc_word,
  output logic               clk_out
);
  div_cfg_t act_cfg;
  div_cfg_t nxt_cfg;
  div_cfg_t enc_cfg;
  logic     stretch_en;
  logic     phase_hi;
  logic     period_end;

  hlclk_encoder u_enc (
    .ratio (enc_ratio),
    .word  (enc_cfg)
  );
  assign enc_word = enc_cfg;

  hlclk_cfg_hold u_cfg (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .word_in    (div_cfg_t'(cfg_word)),
    .period_end (period_end),
    .act_cfg    (act_cfg),
    .nxt_cfg    (nxt_cfg),
    .stretch_en (stretch_en)
  );

  hlclk_phase_ctr u_ctr (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .act_cfg    (act_cfg),
    .nxt_cfg    (nxt_cfg),
    .phase_hi   (phase_hi),
    .period_end (period_end)
  );

  hlclk_out_gate u_gate (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .phase_hi   (phase_hi),
    .stretch_en (stretch_en),
    .byp_sel    (act_cfg.bypass),
    .clk_out    (clk_out)
  );
endmodule

// File: tb/hlclk_divider_tb.sv
`timescale 1ns/1ps
module hlclk_divider_tb;
  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] cfg_word = '0;
  logic        cfg_load = 1'b0;
  logic [6:0]  enc_ratio = '0;
  logic [13:0] enc_word;
  logic        clk_out;

  int n_chk = 0;
  int n_fail = 0;
  logic smp [0:1023];

  always #2 clk_in = ~clk_in;

  hlclk_divider u_dut (
    .clk_in (clk_in), .rst_n (rst_n), .cfg_word (cfg_word), .cfg_load (cfg_load),
    .enc_ratio (enc_ratio), .enc_word (enc_word), .clk_out (clk_out)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mkword(input bit byp, input bit adj, input int hi, input int lo);
    return {byp, adj, 6'(hi), 6'(lo)};
  endfunction

  task automatic load_word(input logic [13:0] w);
    @(negedge clk_in);
    cfg_word = w;
    cfg_load = 1'b1;
    @(negedge clk_in);
    cfg_load = 1'b0;
  endtask

  // one sample per half cycle; even index = high half of clk_in
  task automatic record(input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) @(posedge clk_in); else @(negedge clk_in);
      #1 smp[i] = clk_out;
    end
  endtask

  task automatic check_runs(input string req, input string what, input int n,
                            input int eh, input int el, input int oh, input int ol);
    logic cur;
    int len, nruns, bad_len, bad_exp, last_hi, last_lo;
    bit first, bad;
    record(n);
    cur = smp[0]; len = 1; first = 1; nruns = 0; bad = 0;
    bad_len = 0; bad_exp = 0; last_hi = -1; last_lo = -1;
    for (int i = 1; i < n; i++) begin
      if (smp[i] == cur) len++;
      else begin
        if (!first) begin
          nruns++;
          if (cur) begin
            last_hi = len;
            if (len != eh && len != oh && !bad) begin bad = 1; bad_len = len; bad_exp = eh; end
          end else begin
            last_lo = len;
            if (len != el && len != ol && !bad) begin bad = 1; bad_len = len; bad_exp = el; end
          end
        end
        first = 0; cur = smp[i]; len = 1;
      end
    end
    if (bad) check(0, req, {what, " run width"}, bad_len, bad_exp);
    else if (nruns < 2) check(0, req, {what, " complete runs"}, nruns, 2);
    else if (last_hi != eh) check(0, req, {what, " final high width"}, last_hi, eh);
    else check(last_lo == el, req, {what, " final low width"}, last_lo, el);
  endtask

  task automatic t_reset;
    int ones;
    ones = 0;
    record(8);
    for (int i = 0; i < 8; i++) ones += int'(smp[i]);
    check(ones == 0, "R9", "high samples during reset", ones, 0);
    @(posedge clk_in);
    #1 rst_n = 1'b1;
    record(4);
    check({smp[0], smp[1], smp[2], smp[3]} == 4'b1100, "R9", "first period after release",
          int'({smp[0], smp[1], smp[2], smp[3]}), 12);
  endtask

  function automatic int exp_enc(input int r);
    int n;
    n = (r == 0) ? 1 : (r > 126) ? 126 : r;
    return ((n == 1) << 13) | ((n % 2) << 12) | ((n / 2) << 6) | ((n + 1) / 2);
  endfunction

  task automatic t_encoder;
    int ratios [8] = '{2, 3, 7, 64, 126, 1, 0, 127};
    foreach (ratios[k]) begin
      enc_ratio = 7'(ratios[k]);
      #1;
      check(int'(enc_word) == exp_enc(ratios[k]), (ratios[k] >= 2 && ratios[k] <= 126) ? "R1" : "R2",
            $sformatf("encoded word for ratio %0d", ratios[k]), int'(enc_word), exp_enc(ratios[k]));
    end
    enc_ratio = 7'd6;
    #1;
    load_word(enc_word);
    repeat (20) @(posedge clk_in);
    check_runs("R1", "encoded ratio 6 applied", 120, 6, 6, 6, 6);
  endtask

  task automatic t_steady(input string req, input string what, input logic [13:0] w,
                          input int eh, input int el, input int n);
    load_word(w);
    repeat (300) @(posedge clk_in);
    check_runs(req, what, n, eh, el, eh, el);
  endtask

  task automatic t_switch_divided;
    load_word(mkword(0, 0, 2, 2));
    repeat (20) @(posedge clk_in);
    load_word(mkword(0, 1, 2, 3));
    check_runs("R8", "ratio 4 to ratio 5", 200, 5, 5, 4, 4);
  endtask

  task automatic t_leave_bypass;
    load_word(mkword(1, 1, 0, 1));
    repeat (20) @(posedge clk_in);
    check_runs("R7", "pass-through", 64, 1, 1, 1, 1);
    check(smp[0] == 1'b1, "R7", "pass-through follows high half", int'(smp[0]), 1);
    load_word(mkword(0, 0, 1, 1));
    check_runs("R8", "leave pass-through", 64, 2, 2, 1, 1);
  endtask

  task automatic t_last_wins;
    logic prev;
    load_word(mkword(0, 0, 10, 10));
    repeat (60) @(posedge clk_in);
    prev = 1'b1;
    forever begin
      @(posedge clk_in);
      #1;
      if (clk_out && !prev) break;
      prev = clk_out;
    end
    load_word(mkword(0, 0, 2, 2));
    load_word(mkword(0, 0, 3, 3));
    check_runs("R10", "last of two loads", 200, 6, 6, 20, 20);
  endtask

  initial begin
    t_reset();
    t_encoder();
    t_steady("R4", "even ratio 4", mkword(0, 0, 2, 2), 4, 4, 120);
    t_steady("R4", "asymmetric high 5 low 2", mkword(0, 0, 5, 2), 10, 4, 120);
    t_steady("R3", "zero high count", mkword(0, 0, 0, 4), 2, 8, 120);
    t_steady("R5", "odd ratio 3", mkword(0, 1, 1, 2), 3, 3, 120);
    t_steady("R5", "odd ratio 7", mkword(0, 1, 3, 4), 7, 7, 160);
    t_steady("R5", "odd ratio 125", mkword(0, 1, 62, 63), 125, 125, 900);
    t_steady("R6", "odd-adjust with low 1", mkword(0, 1, 3, 1), 6, 2, 120);
    t_switch_divided();
    t_leave_bypass();
    t_last_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule